// File: doc/BRIEF.md
# Long Call Target Decoder

This block resolves the destination of a 32-bit subroutine-call instruction from the compressed 16-bit instruction set. It takes the two halfwords of the instruction and the address the instruction sits at. It rebuilds the split signed displacement and sign-extends it. From that it produces the call target, the return-link value and a flag telling whether the call also switches execution into the full-width 32-bit instruction set.

There are two call forms. The keep form stays in the compressed set and adds its displacement to the raw program counter. The switch form enters the full-width set and adds its displacement to the program counter rounded down to a word boundary. Inputs that do not carry the call pattern are reported as not-a-branch. A switch form whose lowest bit is set is reported as undefined.

Requests enter through a valid/ready handshake. Each result is held in a single output register until the consumer takes it.

Top module: `lcall_tgt_dec`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o, target_o, link_o, switch_o, not_branch_o and undef_o are all zero and in_ready_o is 1.
- R2: A request is accepted on a rising edge where in_valid_i and in_ready_o are both 1, and its result is shown with out_valid_o = 1 from that edge on. in_ready_o equals (not out_valid_o) or out_ready_i.
- R3: While out_valid_o is 1 and out_ready_i is 0, no request is accepted and every output keeps its value.
- R4: The input is a call only when hw_hi_i[15:11] = 5'b11110 and hw_lo_i[15:14] = 2'b11. Any other input gives not_branch_o = 1 with target_o, link_o, switch_o and undef_o at zero.
- R5: For a call, hw_lo_i[12] selects the form: 1 gives the keep form (switch_o = 0), and 0 gives the switch form (switch_o = 1).
- R6: With sign bit s = hw_hi_i[10], the displacement bits are i1 = NOT(hw_lo_i[13] XOR s) and i2 = NOT(hw_lo_i[11] XOR s).
- R7: In the keep form, target_o = addr_i + 4 + SignExtend({s, i1, i2, hw_hi_i[9:0], hw_lo_i[10:0], 1'b0}).
- R8: In the switch form, target_o = ((addr_i + 4) with bits 1:0 cleared) + SignExtend({s, i1, i2, hw_hi_i[9:0], hw_lo_i[10:1], 2'b00}).
- R9: For the keep and switch forms, link_o = (addr_i + 4) with bit 0 set to 1.
- R10: A switch-form input with hw_lo_i[0] = 1 gives undef_o = 1 with target_o, link_o, switch_o and not_branch_o at zero.
- R11: Halfwords 16'hF7FF and 16'hEFDC at address 32'h8436 give target 32'h83F0, link 32'h843B and switch_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken this cycle |
| hw_hi_i | input | 16 | First halfword of the instruction |
| hw_lo_i | input | 16 | Second halfword of the instruction |
| addr_i | input | ADDR_W | Address of the instruction |
| out_valid_o | output | 1 | Result held in the output register |
| out_ready_i | input | 1 | Consumer takes the result |
| target_o | output | ADDR_W | Call destination |
| link_o | output | ADDR_W | Return address with bit 0 set |
| switch_o | output | 1 | Call enters the full-width set |
| not_branch_o | output | 1 | Input is not a long call |
| undef_o | output | 1 | Switch form with a reserved bit set |

## Verification
Two things can land on the same edge: the consumer draining the held result, and a new request being loaded into the same register. The bench drives out_ready_i at random against a stream of requests that is mostly back-to-back. This gives many cycles where a drain and a load happen together, and many where back-pressure stalls the input. Results are compared in order against a queue of model predictions. A dropped, duplicated or early-overwritten result therefore shows up as a mismatch, and every stalled cycle is also checked for unchanged outputs.

// File: rtl/lcall_pkg.sv
package lcall_pkg;
  localparam int unsigned OFF_W = 25;
  localparam logic [4:0] HI_TAG = 5'b11110;
  localparam logic [1:0] LO_TAG = 2'b11;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_KEEP   = 2'd1,
    KIND_SWITCH = 2'd2,
    KIND_UNDEF  = 2'd3
  } call_kind_e;
endpackage

// File: rtl/lcall_field_split.sv
module lcall_field_split
  import lcall_pkg::*;
(
  input  logic [15:0]      hw_hi_i,
  input  logic [15:0]      hw_lo_i,
  output call_kind_e       kind_o,
  output logic [OFF_W-1:0] offset_o
);
  logic sgn, i1, i2, is_call;

  assign sgn     = hw_hi_i[10];
  assign i1      = ~(hw_lo_i[13] ^ sgn);
  assign i2      = ~(hw_lo_i[11] ^ sgn);
  assign is_call = (hw_hi_i[15:11] == HI_TAG) && (hw_lo_i[15:14] == LO_TAG);

  always_comb begin
    if (!is_call)          kind_o = KIND_NONE;
    else if (hw_lo_i[12])  kind_o = KIND_KEEP;
    else if (hw_lo_i[0])   kind_o = KIND_UNDEF;
    else                   kind_o = KIND_SWITCH;
  end

  always_comb begin
    unique case (kind_o)
      KIND_KEEP:   offset_o = {sgn, i1, i2, hw_hi_i[9:0], hw_lo_i[10:0], 1'b0};
      KIND_SWITCH: offset_o = {sgn, i1, i2, hw_hi_i[9:0], hw_lo_i[10:1], 2'b00};
      default:     offset_o = '0;
    endcase
  end
endmodule

// File: rtl/lcall_addr_calc.sv
module lcall_addr_calc
  import lcall_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  call_kind_e        kind_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] link_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] pc, base, disp;

  assign pc   = addr_i + ADDR_W'(4);
  assign disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  // switch form adds to the word-aligned pc
  assign base = (kind_i == KIND_SWITCH) ? {pc[ADDR_W-1:2], 2'b00} : pc;

  always_comb begin
    if (kind_i == KIND_KEEP || kind_i == KIND_SWITCH) begin
      target_o = base + disp;
      link_o   = {pc[ADDR_W-1:1], 1'b1};
    end else begin
      target_o = '0;
      link_o   = '0;
    end
  end
endmodule

// File: rtl/lcall_tgt_dec.sv
module lcall_tgt_dec
  import lcall_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [15:0]       hw_hi_i,
  input  logic [15:0]       hw_lo_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              switch_o,
  output logic              not_branch_o,
  output logic              undef_o
);
  call_kind_e        kind;
  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] tgt_d, lnk_d;
  logic              accept;

  lcall_field_split u_split (
    .hw_hi_i  (hw_hi_i),
    .hw_lo_i  (hw_lo_i),
    .kind_o   (kind),
    .offset_o (offset)
  );

  lcall_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .addr_i   (addr_i),
    .kind_i   (kind),
    .offset_i (offset),
    .target_o (tgt_d),
    .link_o   (lnk_d)
  );

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      target_o     <= '0;
      link_o       <= '0;
      switch_o     <= 1'b0;
      not_branch_o <= 1'b0;
      undef_o      <= 1'b0;
    end else if (accept) begin
      out_valid_o  <= 1'b1;
      target_o     <= tgt_d;
      link_o       <= lnk_d;
      switch_o     <= (kind == KIND_SWITCH);
      not_branch_o <= (kind == KIND_NONE);
      undef_o      <= (kind == KIND_UNDEF);
    end else if (out_ready_i) begin
      out_valid_o  <= 1'b0;
    end
  end

  // R2
  accept_shows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(target_o) && $stable(link_o)
      && $stable(switch_o) && $stable(not_branch_o) && $stable(undef_o));

  // R4
  not_branch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && not_branch_o |-> target_o == '0 && link_o == '0 && !switch_o && !undef_o);

  // R8
  switch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && switch_o |-> target_o[1:0] == 2'b00 && !undef_o);

  // R9
  link_mode_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !not_branch_o && !undef_o |-> link_o[0]);

  // R10
  undef_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && undef_o |-> target_o == '0 && link_o == '0 && !switch_o && !not_branch_o);
endmodule

// File: tb/lcall_tgt_dec_tb_top.sv
module lcall_tgt_dec_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [15:0] hw_hi_i = '0;
  logic [15:0] hw_lo_i = '0;
  logic [31:0] addr_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] target_o, link_o;
  logic        switch_o, not_branch_o, undef_o;

  always #2 clk_i = ~clk_i;

  lcall_tgt_dec #(.ADDR_W(32)) dut_i (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .hw_hi_i, .hw_lo_i, .addr_i,
    .out_valid_o, .out_ready_i, .target_o, .link_o, .switch_o, .not_branch_o, .undef_o
  );

  typedef struct {
    logic [31:0] tgt;
    logic [31:0] lnk;
    logic        sw, nb, ud, worked;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] a, input logic [15:0] b, input logic [31:0] ad);
    exp_t e;
    logic s, i1, i2;
    logic [24:0] raw;
    logic [31:0] base, off;
    e.tgt = '0; e.lnk = '0; e.sw = 0; e.nb = 0; e.ud = 0; e.worked = 0;
    if (a[15:11] != 5'b11110 || b[15:14] != 2'b11) begin e.nb = 1; return e; end
    if (b[12] == 1'b0 && b[0] == 1'b1) begin e.ud = 1; return e; end
    s  = a[10];
    i1 = (b[13] == s);
    i2 = (b[11] == s);
    if (b[12]) raw = {s, i1, i2, a[9:0], b[10:0], 1'b0};
    else       raw = {s, i1, i2, a[9:0], b[10:1], 2'b00};
    off  = raw[24] ? (32'hFE00_0000 | {7'd0, raw}) : {7'd0, raw};
    base = ad + 32'd4;
    if (!b[12]) base = base & 32'hFFFF_FFFC;
    e.tgt = base + off;
    e.lnk = (ad + 32'd4) | 32'd1;
    e.sw  = !b[12];
    return e;
  endfunction

  // directed corner cases then constrained random
  task automatic pick(input int idx, output logic [15:0] a, output logic [15:0] b, output logic [31:0] ad);
    int r;
    case (idx)
      0: begin a = 16'hF7FF; b = 16'hEFDC; ad = 32'h0000_8436; end
      1: begin a = 16'hF3FF; b = 16'hD7FF; ad = 32'h0000_1000; end  // max positive keep
      2: begin a = 16'hF400; b = 16'hD000; ad = 32'h0100_0002; end  // max negative keep
      3: begin a = 16'hF000; b = 16'hC7FE; ad = 32'hFFFF_FFFE; end  // wrap past top
      4: begin a = 16'hF000; b = 16'hC001; ad = 32'h0000_2000; end  // undef
      5: begin a = 16'hE800; b = 16'hF800; ad = 32'h0000_3000; end  // not a call
      default: begin
        r  = $urandom % 10;
        a  = 16'($urandom);
        b  = 16'($urandom);
        ad = $urandom;
        if (r < 8) begin
          a[15:11] = 5'b11110;
          b[15:14] = 2'b11;
          if (r < 3) b[0] = 1'b0;
        end else if (r == 8) begin
          b[15:14] = 2'b11;
        end
      end
    endcase
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int sent, total;
    bit pend, hold_pend, exp_valid;
    logic [31:0] h_tgt, h_lnk;
    logic [2:0]  h_flags;
    logic [15:0] a, b;
    logic [31:0] ad;
    exp_t e;
    seed  = $urandom(32'd2024);
    total = 4000;
    sent  = 0;
    pend  = 0;
    hold_pend = 0;
    exp_valid = 0;

    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(out_valid_o == 0 && target_o == 0 && link_o == 0 && !switch_o && !not_branch_o && !undef_o,
        "R1 reset outputs", {out_valid_o, switch_o, not_branch_o, undef_o}, 0);
    chk(in_ready_o == 1, "R1 ready in reset", in_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 0 && target_o == 0 && link_o == 0, "R1 after release", out_valid_o, 0);

    while (sent < total || q.size() != 0) begin
      @(negedge clk_i);
      if (exp_valid) chk(out_valid_o == 1, "R2 result shown after accept", out_valid_o, 1);
      exp_valid = 0;
      if (hold_pend) begin
        chk(out_valid_o && target_o == h_tgt && link_o == h_lnk &&
            {switch_o, not_branch_o, undef_o} == h_flags, "R3 held outputs", target_o, h_tgt);
        hold_pend = 0;
      end
      out_ready_i = (sent >= total) ? 1'b1 : (($urandom % 4) != 0);
      if (!pend) begin
        if (sent < total && (sent < 6 || ($urandom % 8) != 0)) begin
          pick(sent, a, b, ad);
          hw_hi_i = a; hw_lo_i = b; addr_i = ad;
          in_valid_i = 1'b1;
          pend = 1;
        end else begin
          in_valid_i = 1'b0;
        end
      end
      #1;
      chk(in_ready_o == (!out_valid_o || out_ready_i), "R2 ready rule", in_ready_o, !out_valid_o || out_ready_i);
      if (out_valid_o && out_ready_i) begin
        if (q.size() == 0) begin
          chk(0, "R2 unexpected result", target_o, 0);
        end else begin
          e = q.pop_front();
          if (e.nb)      chk(target_o == e.tgt, "R4 target", target_o, e.tgt);
          else if (e.ud) chk(target_o == e.tgt, "R10 target", target_o, e.tgt);
          else if (e.sw) chk(target_o == e.tgt, "R8 R6 target", target_o, e.tgt);
          else           chk(target_o == e.tgt, "R7 R6 target", target_o, e.tgt);
          chk(link_o == e.lnk, "R9 link", link_o, e.lnk);
          chk(switch_o == e.sw, "R5 switch flag", switch_o, e.sw);
          chk(not_branch_o == e.nb, "R4 not-branch flag", not_branch_o, e.nb);
          chk(undef_o == e.ud, "R10 undef flag", undef_o, e.ud);
          if (e.worked) begin
            chk(target_o == 32'h83F0, "R11 worked target", target_o, 32'h83F0);
            chk(link_o == 32'h843B && switch_o, "R11 worked link", link_o, 32'h843B);
          end
        end
      end else if (out_valid_o) begin
        chk(!in_ready_o, "R3 no accept while held", in_ready_o, 0);
        hold_pend = 1;
        h_tgt = target_o; h_lnk = link_o;
        h_flags = {switch_o, not_branch_o, undef_o};
      end
      if (in_valid_i && in_ready_o) begin
        e = model(hw_hi_i, hw_lo_i, addr_i);
        e.worked = (sent == 0);
        q.push_back(e);
        sent++;
        pend = 0;
        exp_valid = 1;
        hold_pend = 0;
      end
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule